// File: doc/BRIEF.md
# Reset Sequencer with Acknowledge Delay

This block sequences the resets of a packet-security datapath core. It takes an active-low cold reset that covers the whole core, plus two narrower active-low resets. One of the narrower resets covers only the register domain. The other covers only the streaming logic. Each reset domain gets its own output. Every output goes low at once, with no clock, when its sources go low. Each output comes back high only after its sources have been high through a chain of synchronizer flops clocked by the core clock.

The block also answers the cold reset with an active-low acknowledge. Each time the cold reset changes level, a countdown is loaded from a delay field. The acknowledge takes the new level only when that countdown reaches zero. If the cold reset changes again while a countdown is running, the count restarts. The acknowledge therefore shows only the level at which the input settles.

A software run bit lives in the register domain. While the bit is 0, the core datapath is held in reset and the transmit and receive traffic gates stay closed. The register domain and the bit itself keep their contents during this software reset. The bit powers up at 0, so software must write 1 before any traffic passes.

Top module: `pkt_core_rst_seq`

## Requirements
- R1: `csr_rst_n` goes low with no clock edge whenever `cold_rst_n` or `csr_arst_n` is low. After both inputs are high, it goes high on the second rising clock edge.
- R2: `strm_rst_n` goes low with no clock edge whenever `cold_rst_n` or `strm_arst_n` is low. After both inputs are high, it goes high on the second rising clock edge.
- R3: A low on `csr_arst_n` leaves `strm_rst_n` high. A low on `strm_arst_n` leaves `csr_rst_n` high.
- R4: After `cold_rst_n` changes level between two clock edges, `cold_ack_n` takes that level on rising edge N+4, counting the first edge after the change as edge 1. N is the value on `ack_delay` at the moment the change is seen. Until that edge, `cold_ack_n` keeps its old value.
- R5: If `cold_rst_n` changes again before the countdown ends, the count reloads. `cold_ack_n` then changes only once, to the final settled level, timed from the last change. It never shows a level that was abandoned.
- R6: With `ack_delay` = 0, `cold_ack_n` follows a change of `cold_rst_n` on the fourth rising edge.
- R7: `sw_run` is cleared to 0 with no clock edge by a low on `csr_rst_n`. After that, it takes `sw_wr_data` on each rising edge where `sw_wr_en` is 1. Writes made while `csr_rst_n` is low have no effect.
- R8: While `sw_run` is 0, `core_rst_n` is low, even with `strm_rst_n` high. A streaming-domain reset does not change `sw_run`.
- R9: `tx_pass` and `rx_pass` are 0 whenever `core_rst_n` is low. Both become 1 on the first rising edge after `core_rst_n` has been high through a clock edge.
- R10: At power-up, before any change of `cold_rst_n` has been counted out, `cold_ack_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| cold_rst_n | input | 1 | Active-low cold reset for the whole core |
| csr_arst_n | input | 1 | Active-low reset for the register domain only |
| strm_arst_n | input | 1 | Active-low reset for the streaming logic only |
| ack_delay | input | CNT_W | Countdown reload value for the acknowledge |
| sw_wr_en | input | 1 | Write strobe for the software run bit |
| sw_wr_data | input | 1 | Value written to the software run bit |
| cold_ack_n | output | 1 | Delayed active-low cold-reset acknowledge |
| csr_rst_n | output | 1 | Register-domain reset enable, active low |
| strm_rst_n | output | 1 | Streaming-domain reset enable, active low |
| core_rst_n | output | 1 | Core datapath reset enable, including the software reset, active low |
| sw_run | output | 1 | Current value of the software run bit |
| tx_pass | output | 1 | Transmit traffic gate |
| rx_pass | output | 1 | Receive traffic gate |

## Verification
The bench builds the block with a 6-bit delay field, two synchronizer stages and the registered traffic gate. With a narrow count, delays of 0, 3, 5, 10 and 20 can each be counted out in a few dozen cycles. This brings the zero-delay case and the restart after a retoggle within reach. The two-stage chains make the release edge of each domain an exact, checkable cycle. The registered gate variant exposes the one-edge lag between `core_rst_n` rising and the traffic gates opening.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   // Countdown phase of the acknowledge sequencer
   typedef enum logic {
      CD_IDLE = 1'b0,
      CD_RUN  = 1'b1
   } cd_state_e;

   // Fewest flops allowed in any reset-release chain
   localparam int MIN_SYNC_STAGES = 2;

   // Widest countdown field supported
   localparam int MAX_CNT_W = 32;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_o
);
   import rst_seq_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("rst_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = chain[STAGES-1];

   // R1
   rel_after_src_chk: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(rst_n_o) |-> $past(arst_n));

endmodule

// File: rtl/ack_countdown.sv
module ack_countdown #(
   parameter int CNT_W  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             lvl_in,
   input  logic [CNT_W-1:0] reload,
   output logic             ack_o
);
   import rst_seq_pkg::*;

   if (CNT_W < 1 || CNT_W > MAX_CNT_W) begin : g_bad_cnt
      $error("ack_countdown: CNT_W out of range");
   end
   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("ack_countdown: STAGES below minimum");
   end

   // Power-up values: reset seen as asserted and already acknowledged
   logic [STAGES-1:0] smp   = '0;
   logic              last  = 1'b0;
   logic [CNT_W-1:0]  cnt   = '0;
   cd_state_e         st    = CD_IDLE;
   logic              ack_q = 1'b0;
   logic              lvl;
   logic              moved;

   assign lvl   = smp[STAGES-1];
   assign moved = (lvl != last);

   always_ff @(posedge clk) begin
      smp  <= {smp[STAGES-2:0], lvl_in};
      last <= lvl;
      if (moved) begin
         cnt <= reload;
         st  <= CD_RUN;
      end else if (st == CD_RUN) begin
         if (cnt == '0) begin
            ack_q <= lvl;
            st    <= CD_IDLE;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign ack_o = ack_q;

   // R4
   hold_while_counting_chk: assert property (@(posedge clk)
      (st == CD_RUN && cnt != '0 && !moved) |=> $stable(ack_q));

   // R4
   hold_while_idle_chk: assert property (@(posedge clk)
      (st == CD_IDLE && !moved) |=> $stable(ack_q));

   // R5
   ack_takes_settled_chk: assert property (@(posedge clk)
      !$stable(ack_q) |-> (ack_q == $past(lvl)));

endmodule

// File: rtl/sw_run_reg.sv
module sw_run_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_data,
   output logic run_o
);
   logic run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= 1'b0;
      else if (wr_en) run_q <= wr_data;
   end

   assign run_o = run_q;

   // R7
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (run_o == $past(wr_data)));

endmodule

// File: rtl/traffic_gate.sv
module traffic_gate #(
   parameter bit GATE_REG = 1'b1
) (
   input  logic clk,
   input  logic core_rst_n,
   output logic tx_pass,
   output logic rx_pass
);
   logic open_q;

   if (GATE_REG) begin : g_reg
      always_ff @(posedge clk or negedge core_rst_n) begin
         if (!core_rst_n) open_q <= 1'b0;
         else             open_q <= 1'b1;
      end
   end else begin : g_comb
      assign open_q = core_rst_n;
   end

   assign tx_pass = open_q;
   assign rx_pass = open_q;

   // R9
   gate_closed_chk: assert property (@(posedge clk)
      !core_rst_n |-> (!tx_pass && !rx_pass));

endmodule

// File: rtl/pkt_core_rst_seq.sv
module pkt_core_rst_seq #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit GATE_REG    = 1'b1
) (
   input  logic             clk,
   input  logic             cold_rst_n,
   input  logic             csr_arst_n,
   input  logic             strm_arst_n,
   input  logic [CNT_W-1:0] ack_delay,
   input  logic             sw_wr_en,
   input  logic             sw_wr_data,
   output logic             cold_ack_n,
   output logic             csr_rst_n,
   output logic             strm_rst_n,
   output logic             core_rst_n,
   output logic             sw_run,
   output logic             tx_pass,
   output logic             rx_pass
);
   localparam int N_DOM   = 2;
   localparam int DOM_CSR = 0;
   localparam int DOM_STR = 1;

   logic [N_DOM-1:0] dom_src_n;
   logic [N_DOM-1:0] dom_out_n;

   assign dom_src_n[DOM_CSR] = cold_rst_n & csr_arst_n;
   assign dom_src_n[DOM_STR] = cold_rst_n & strm_arst_n;

   for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .arst_n  (dom_src_n[d]),
         .rst_n_o (dom_out_n[d])
      );
   end

   assign csr_rst_n  = dom_out_n[DOM_CSR];
   assign strm_rst_n = dom_out_n[DOM_STR];

   ack_countdown #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_ack (
      .clk    (clk),
      .lvl_in (cold_rst_n),
      .reload (ack_delay),
      .ack_o  (cold_ack_n)
   );

   sw_run_reg u_swrun (
      .clk     (clk),
      .rst_n   (csr_rst_n),
      .wr_en   (sw_wr_en),
      .wr_data (sw_wr_data),
      .run_o   (sw_run)
   );

   assign core_rst_n = strm_rst_n & sw_run;

   traffic_gate #(.GATE_REG(GATE_REG)) u_gate (
      .clk        (clk),
      .core_rst_n (core_rst_n),
      .tx_pass    (tx_pass),
      .rx_pass    (rx_pass)
   );

   // R8
   run_kept_on_strm_rst_chk: assert property (@(posedge clk) disable iff (!csr_rst_n)
      $fell(strm_rst_n) |=> $stable(sw_run));

endmodule

// File: tb/pkt_core_rst_seq_tb.sv
module pkt_core_rst_seq_tb;
   localparam int CNT_W = 6;

   logic             clk = 1'b0;
   logic             cold_rst_n = 1'b0;
   logic             csr_arst_n = 1'b1;
   logic             strm_arst_n = 1'b1;
   logic [CNT_W-1:0] ack_delay = 6'd5;
   logic             sw_wr_en = 1'b0;
   logic             sw_wr_data = 1'b0;
   logic             cold_ack_n, csr_rst_n, strm_rst_n, core_rst_n, sw_run, tx_pass, rx_pass;

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   int   exp_cyc[$];
   logic exp_lvl[$];
   logic ack_prev = 1'b0;

   pkt_core_rst_seq #(.CNT_W(CNT_W), .SYNC_STAGES(2), .GATE_REG(1'b1)) u_dut (
      .clk(clk), .cold_rst_n(cold_rst_n), .csr_arst_n(csr_arst_n), .strm_arst_n(strm_arst_n),
      .ack_delay(ack_delay), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
      .cold_ack_n(cold_ack_n), .csr_rst_n(csr_rst_n), .strm_rst_n(strm_rst_n),
      .core_rst_n(core_rst_n), .sw_run(sw_run), .tx_pass(tx_pass), .rx_pass(rx_pass)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // Scoreboard monitor for the acknowledge
   always @(negedge clk) begin
      if (cold_ack_n !== ack_prev) begin
         if (exp_cyc.size() == 0) begin
            check("R5 unexpected ack change", 1, 0);
         end else begin
            check("R4 ack level", int'(cold_ack_n), int'(exp_lvl[0]));
            check("R4 ack cycle", cyc, exp_cyc[0]);
            void'(exp_cyc.pop_front());
            void'(exp_lvl.pop_front());
         end
      end
      ack_prev = cold_ack_n;
   end

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Driver: change cold reset, optionally pushing the expected ack event
   task automatic drive_cold(input logic lvl, input bit expect_ev);
      cold_rst_n = lvl;
      if (expect_ev) begin
         exp_lvl.push_back(lvl);
         exp_cyc.push_back(cyc + 4 + int'(ack_delay));
      end
   endtask

   task automatic sw_write(input logic v);
      sw_wr_en = 1'b1; sw_wr_data = v;
      @(negedge clk);
      sw_wr_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      wait_neg(5000);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      wait_neg(3);
      check("R10 ack at power-up", int'(cold_ack_n), 0);
      check("R1 csr in cold reset", int'(csr_rst_n), 0);
      check("R2 strm in cold reset", int'(strm_rst_n), 0);
      check("R7 sw_run reset value", int'(sw_run), 0);
      check("R9 tx closed", int'(tx_pass), 0);

      drive_cold(1'b1, 1'b1);
      wait_neg(1);
      check("R1 csr held after edge 1", int'(csr_rst_n), 0);
      wait_neg(1);
      check("R1 csr released at edge 2", int'(csr_rst_n), 1);
      check("R2 strm released at edge 2", int'(strm_rst_n), 1);
      check("R8 core held by sw_run", int'(core_rst_n), 0);
      check("R9 rx closed", int'(rx_pass), 0);
      wait_neg(12);

      sw_write(1'b1);
      check("R7 sw_run written", int'(sw_run), 1);
      check("R8 core released", int'(core_rst_n), 1);
      check("R9 tx lags one edge", int'(tx_pass), 0);
      wait_neg(1);
      check("R9 tx open", int'(tx_pass), 1);
      check("R9 rx open", int'(rx_pass), 1);

      strm_arst_n = 1'b0; #1;
      check("R2 strm async assert", int'(strm_rst_n), 0);
      check("R9 tx closes at once", int'(tx_pass), 0);
      check("R3 csr unaffected", int'(csr_rst_n), 1);
      wait_neg(1);
      strm_arst_n = 1'b1;
      wait_neg(2);
      check("R8 sw_run kept", int'(sw_run), 1);
      check("R2 strm released", int'(strm_rst_n), 1);
      wait_neg(1);
      check("R9 tx reopened", int'(tx_pass), 1);

      sw_write(1'b0);
      check("R8 core held by sw write", int'(core_rst_n), 0);
      check("R8 strm unaffected", int'(strm_rst_n), 1);
      check("R9 rx closed by sw", int'(rx_pass), 0);
      sw_write(1'b1);

      csr_arst_n = 1'b0; #1;
      check("R1 csr async assert", int'(csr_rst_n), 0);
      check("R7 sw_run cleared", int'(sw_run), 0);
      check("R3 strm unaffected", int'(strm_rst_n), 1);
      sw_write(1'b1);
      check("R7 write ignored in reset", int'(sw_run), 0);
      csr_arst_n = 1'b1;
      wait_neg(2);
      check("R1 csr released", int'(csr_rst_n), 1);
      sw_write(1'b1);

      ack_delay = 6'd3;
      drive_cold(1'b0, 1'b1); #1;
      check("R1 cold asserts csr", int'(csr_rst_n), 0);
      wait_neg(10);
      ack_delay = 6'd0;
      drive_cold(1'b1, 1'b1);
      wait_neg(8);
      check("R6 ack high", int'(cold_ack_n), 1);

      ack_delay = 6'd20;
      drive_cold(1'b0, 1'b0);
      wait_neg(6);
      drive_cold(1'b1, 1'b0);
      wait_neg(40);
      check("R5 ack stayed high", int'(cold_ack_n), 1);

      ack_delay = 6'd10;
      drive_cold(1'b0, 1'b0);
      wait_neg(5);
      drive_cold(1'b1, 1'b0);
      wait_neg(4);
      drive_cold(1'b0, 1'b1);
      wait_neg(25);
      check("R5 ack settled low", int'(cold_ack_n), 0);
      check("R4 scoreboard drained", exp_cyc.size(), 0);

      done = 1'b1;
      finish_run();
   end
endmodule